// File: doc/BRIEF.md
# One-Bit Special Register Bank

This block holds the handful of single-bit registers that a tiny boolean processor core works on: two operand registers that feed the boolean unit, a result register that the boolean unit fills, one general-purpose register, a latched user input bit with a pending indicator, and an output register that feeds an external display history. The core reaches the bank through a read port and a write port. Each port takes a 2-bit selector, and the same selector value names a different register depending on which port it arrives on.

The pending indicator is set when the user presents a new input bit. Reading it through the read port clears it, so the core can poll for fresh input. Every write to the output register raises a one-cycle strobe to the display circuitry, carrying the new value with it.

Top module: `bit_reg_bank`

## Requirements
- R1: After a synchronous reset every register is 0. Every readable selector returns 0, `opa_bit` and `opb_bit` are 0, and `disp_stb` and `disp_bit` are 0.
- R2: The read selector picks a register combinationally in the same cycle: 2'b00 general register, 2'b01 result register, 2'b10 input bit, 2'b11 pending flag.
- R3: When `wr_en` is high, the write selector picks the target, which takes `wr_data` at the clock edge: 2'b00 general register, 2'b01 output register, 2'b10 operand A (`opa_bit`), 2'b11 operand B (`opb_bit`).
- R4: The result register changes only when `res_we` is high, and then it takes `res_data`. No write-port access alters it.
- R5: When `usr_stb` is high, `usr_bit` is stored in the input register and the pending flag is set, both on the same edge.
- R6: A read with `rd_en` high and selector 2'b11 returns the current flag value and clears the flag at that edge.
- R7: If a clearing flag read and `usr_stb` occur in the same cycle, the flag stays 1.
- R8: Reads with any selector other than 2'b11, and reads with `rd_en` low, leave the flag unchanged.
- R9: A write to the output register makes `disp_stb` high for exactly the one cycle after the write edge, with `disp_bit` equal to the written value. Writes to other targets raise no strobe.
- R10: A write to one target leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read access strobe; a read of the flag with this high clears the flag |
| rd_code | input | 2 | Read selector |
| rd_data | output | 1 | Selected read value |
| wr_en | input | 1 | Write enable |
| wr_code | input | 2 | Write selector |
| wr_data | input | 1 | Write value |
| res_we | input | 1 | Result write enable from the boolean unit |
| res_data | input | 1 | Result bit from the boolean unit |
| usr_stb | input | 1 | User input strobe |
| usr_bit | input | 1 | User input bit |
| opa_bit | output | 1 | Operand A to the boolean unit |
| opb_bit | output | 1 | Operand B to the boolean unit |
| disp_stb | output | 1 | One-cycle display update strobe |
| disp_bit | output | 1 | Current output register value |

## Verification
Each write target is driven with both 1 and 0 while the other targets are held at known, distinct values. This exposes swapped selector decoding and cross-writes between registers. The flag is tested in three ways: with a plain clearing read, with a read under a non-flag selector or with `rd_en` low, and with a clearing read that coincides with a new user strobe. These three cases separate clear-on-read from set priority. Output writes are issued back-to-back and separated by other writes, which shows that the strobe is a pulse tied to each write rather than a level.

// File: rtl/bitreg_pkg.sv
package bitreg_pkg;
    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        RSEL_GEN  = 2'b00,
        RSEL_RES  = 2'b01,
        RSEL_IN   = 2'b10,
        RSEL_FLAG = 2'b11
    } rsel_e;

    typedef enum logic [CODE_W-1:0] {
        WSEL_GEN = 2'b00,
        WSEL_OUT = 2'b01,
        WSEL_OPA = 2'b10,
        WSEL_OPB = 2'b11
    } wsel_e;

    typedef struct packed {
        logic gen;
        logic outv;
        logic opa;
        logic opb;
    } wbank_t;

    function automatic logic is_flag_read(input logic en, input logic [CODE_W-1:0] code);
        return en && (rsel_e'(code) == RSEL_FLAG);
    endfunction
endpackage

// File: rtl/brb_wbank.sv
module brb_wbank
    import bitreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              wr_data,
    output wbank_t            bank,
    output logic              disp_stb
);
    wsel_e sel;
    assign sel = wsel_e'(wr_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            bank     <= '0;
            disp_stb <= 1'b0;
        end else begin
            disp_stb <= wr_en && (sel == WSEL_OUT);
            if (wr_en) begin
                case (sel)
                    WSEL_GEN: bank.gen  <= wr_data;
                    WSEL_OUT: bank.outv <= wr_data;
                    WSEL_OPA: bank.opa  <= wr_data;
                    WSEL_OPB: bank.opb  <= wr_data;
                    default:  bank      <= bank;
                endcase
            end
        end
    end

    AST_DISP_VALUE: assert property (@(posedge clk) disable iff (rst)
        disp_stb |-> bank.outv == $past(wr_data)); // R9
    AST_GEN_KEEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel != WSEL_GEN) |=> $stable(bank.gen)); // R10
    AST_OPA_KEEP: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel == WSEL_OPA) |=> $stable(bank.opa)); // R10
endmodule

// File: rtl/brb_inlatch.sv
module brb_inlatch (
    input  logic clk,
    input  logic rst,
    input  logic usr_stb,
    input  logic usr_bit,
    input  logic flag_clr,
    output logic in_q,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            in_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (usr_stb) begin
                in_q   <= usr_bit;
                flag_q <= 1'b1;
            end else if (flag_clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        usr_stb |=> flag_q); // R5
    AST_IN_LATCH: assert property (@(posedge clk) disable iff (rst)
        usr_stb |=> in_q == $past(usr_bit)); // R5
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !usr_stb) |=> !flag_q); // R6
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!flag_clr && !usr_stb) |=> $stable(flag_q)); // R8
endmodule

// File: rtl/brb_result.sv
module brb_result (
    input  logic clk,
    input  logic rst,
    input  logic res_we,
    input  logic res_data,
    output logic r_q
);
    always_ff @(posedge clk) begin
        if (rst)         r_q <= 1'b0;
        else if (res_we) r_q <= res_data;
    end

    AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
        !res_we |=> $stable(r_q)); // R4
endmodule

// File: rtl/brb_rdmux.sv
module brb_rdmux
    import bitreg_pkg::*;
(
    input  logic [CODE_W-1:0] rd_code,
    input  logic              gen_q,
    input  logic              r_q,
    input  logic              in_q,
    input  logic              flag_q,
    output logic              rd_data
);
    always_comb begin
        case (rsel_e'(rd_code))
            RSEL_GEN:  rd_data = gen_q;
            RSEL_RES:  rd_data = r_q;
            RSEL_IN:   rd_data = in_q;
            RSEL_FLAG: rd_data = flag_q;
            default:   rd_data = 1'b0;
        endcase
    end
endmodule

// File: rtl/bit_reg_bank.sv
module bit_reg_bank
    import bitreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [CODE_W-1:0] rd_code,
    output logic              rd_data,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              wr_data,
    input  logic              res_we,
    input  logic              res_data,
    input  logic              usr_stb,
    input  logic              usr_bit,
    output logic              opa_bit,
    output logic              opb_bit,
    output logic              disp_stb,
    output logic              disp_bit
);
    wbank_t bank;
    logic   r_q, in_q, flag_q, flag_clr;

    assign flag_clr = is_flag_read(rd_en, rd_code);

    brb_wbank u_wbank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wr_code),
        .wr_data(wr_data), .bank(bank), .disp_stb(disp_stb)
    );

    brb_inlatch u_inlatch (
        .clk(clk), .rst(rst), .usr_stb(usr_stb), .usr_bit(usr_bit),
        .flag_clr(flag_clr), .in_q(in_q), .flag_q(flag_q)
    );

    brb_result u_result (
        .clk(clk), .rst(rst), .res_we(res_we), .res_data(res_data), .r_q(r_q)
    );

    brb_rdmux u_rdmux (
        .rd_code(rd_code), .gen_q(bank.gen), .r_q(r_q), .in_q(in_q),
        .flag_q(flag_q), .rd_data(rd_data)
    );

    assign opa_bit  = bank.opa;
    assign opb_bit  = bank.opb;
    assign disp_bit = bank.outv;

    AST_STB_PULSE: assert property (@(posedge clk) disable iff (rst)
        (disp_stb && !$past(wr_en && wr_code == WSEL_OUT)) |-> 1'b0); // R9
    AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && usr_stb) |=> flag_q); // R7
endmodule

// File: tb/test_bit_reg_bank.sv
module test_bit_reg_bank;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_en = 1'b0, wr_en = 1'b0, wr_data = 1'b0;
    logic [1:0] rd_code = 2'b00, wr_code = 2'b00;
    logic       res_we = 1'b0, res_data = 1'b0, usr_stb = 1'b0, usr_bit = 1'b0;
    logic       rd_data, opa_bit, opb_bit, disp_stb, disp_bit;
    int         total = 0, bad = 0;
    bit         finished = 1'b0;

    always #4 clk = ~clk;

    bit_reg_bank i_bit_reg_bank (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_code(rd_code), .rd_data(rd_data),
        .wr_en(wr_en), .wr_code(wr_code), .wr_data(wr_data), .res_we(res_we),
        .res_data(res_data), .usr_stb(usr_stb), .usr_bit(usr_bit),
        .opa_bit(opa_bit), .opb_bit(opb_bit), .disp_stb(disp_stb), .disp_bit(disp_bit)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    function automatic logic peek_fn(input logic [1:0] c);
        return 1'b0;
    endfunction

    task automatic peek(input logic [1:0] c, output logic v);
        rd_en = 1'b0; rd_code = c; #1; v = rd_data;
    endtask

    task automatic wr(input logic [1:0] c, input logic d);
        wr_en = 1'b1; wr_code = c; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        logic v;
        for (int c = 0; c < 3; c++) begin
            peek(2'(c), v); chk("R1 read after reset", v, 1'b0);
        end
        peek(2'b11, v); chk("R1 flag after reset", v, 1'b0);
        chk("R1 opa", opa_bit, 1'b0); chk("R1 opb", opb_bit, 1'b0);
        chk("R1 disp_stb", disp_stb, 1'b0); chk("R1 disp_bit", disp_bit, 1'b0);
    endtask

    task automatic t_writes();
        logic v;
        wr(2'b00, 1'b1); peek(2'b00, v); chk("R3 gen=1", v, 1'b1);
        chk("R9 no strobe on gen write", disp_stb, 1'b0);
        wr(2'b10, 1'b1); chk("R3 opa=1", opa_bit, 1'b1);
        chk("R10 opb untouched", opb_bit, 1'b0);
        peek(2'b00, v); chk("R10 gen kept", v, 1'b1);
        wr(2'b11, 1'b1); chk("R3 opb=1", opb_bit, 1'b1);
        wr(2'b10, 1'b0); chk("R3 opa=0", opa_bit, 1'b0);
        chk("R10 opb kept", opb_bit, 1'b1);
        wr(2'b00, 1'b0); peek(2'b00, v); chk("R3 gen=0", v, 1'b0);
        peek(2'b01, v); chk("R4 result untouched by writes", v, 1'b0);
    endtask

    task automatic t_result();
        logic v;
        res_we = 1'b1; res_data = 1'b1; step(); res_we = 1'b0;
        peek(2'b01, v); chk("R4 result loaded", v, 1'b1);
        res_data = 1'b0; step();
        peek(2'b01, v); chk("R4 result held without we", v, 1'b1);
        wr(2'b00, 1'b1); peek(2'b01, v); chk("R2 result sel", v, 1'b1);
        peek(2'b00, v); chk("R2 gen sel", v, 1'b1);
    endtask

    task automatic t_output();
        wr(2'b01, 1'b1);
        chk("R9 strobe after out write", disp_stb, 1'b1);
        chk("R9 disp value 1", disp_bit, 1'b1);
        wr(2'b01, 1'b0);
        chk("R9 strobe back-to-back", disp_stb, 1'b1);
        chk("R9 disp value 0", disp_bit, 1'b0);
        step();
        chk("R9 strobe single cycle", disp_stb, 1'b0);
        wr(2'b11, 1'b0);
        chk("R9 no strobe on opb write", disp_stb, 1'b0);
        chk("R10 out kept", disp_bit, 1'b0);
    endtask

    task automatic t_flag();
        logic v;
        usr_stb = 1'b1; usr_bit = 1'b1; step(); usr_stb = 1'b0; usr_bit = 1'b0;
        peek(2'b10, v); chk("R5 input latched", v, 1'b1);
        peek(2'b11, v); chk("R5 flag set", v, 1'b1);
        rd_en = 1'b1; rd_code = 2'b10; step(); rd_en = 1'b0;
        peek(2'b11, v); chk("R8 in read keeps flag", v, 1'b1);
        step();
        peek(2'b11, v); chk("R8 idle keeps flag", v, 1'b1);
        rd_en = 1'b1; rd_code = 2'b11; #1;
        chk("R6 read returns pending 1", rd_data, 1'b1);
        step(); rd_en = 1'b0;
        peek(2'b11, v); chk("R6 flag cleared", v, 1'b0);
        peek(2'b10, v); chk("R6 input kept", v, 1'b1);
        usr_stb = 1'b1; usr_bit = 1'b0; step(); usr_stb = 1'b0;
        rd_en = 1'b1; rd_code = 2'b11; usr_stb = 1'b1; usr_bit = 1'b1; step();
        rd_en = 1'b0; usr_stb = 1'b0;
        peek(2'b11, v); chk("R7 strobe wins over clear", v, 1'b1);
        peek(2'b10, v); chk("R7 input updated", v, 1'b1);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        t_reset();
        t_writes();
        t_result();
        t_output();
        t_flag();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule